// File: doc/BRIEF.md
# Watchdog Timer with Frequency Recovery Request

This block is the timeout watchdog inside the control logic of a clock generator. Software writes one control register. That register holds a timeout code, an arm bit, a reload bit and a recovery-source bit. If software stops servicing the watchdog, the block counts whole seconds up to the programmed limit. It then raises a one-cycle request that tells the frequency selection logic to revert. Along with the request, it states which source the frequency selection logic should restore: the hardware-latched select inputs, or the most recent software-programmed frequency values. A sticky alarm flag records the timeout until software explicitly clears it.

A seconds tick comes from a prescaler that divides the system clock by a parameter. The prescaler is cleared each time the count restarts, so a timeout code N always corresponds to exactly 2·N·DIV clock cycles.

The control register layout is as follows:
- bits [3:0]: timeout code
- bit 4: reload (write-only, reads 0)
- bit 5: alarm (read-only)
- bit 6: recovery source
- bit 7: arm

Top module: `wdr_watchdog_top`

## Requirements
- R1: After reset every control register bit reads 0, and both `alarm` and `recover_req` are low.
- R2: While the timeout code (bits [3:0]) is 0000, no timeout occurs, even when the arm bit (bit 7) is 1.
- R3: With arm=1 and code N (1..15), `recover_req` rises exactly 2·N·TICK_DIV clock edges after the write edge that started the count.
- R4: `recover_req` is high for exactly one cycle, and `alarm` rises on the same edge. The count then stops, and no further request appears until the count is restarted.
- R5: `alarm` (readable at bit 5) stays 1 through any write whose code field is nonzero. A write with code 0000 clears it on that write edge.
- R6: A write with the reload bit (bit 4) set and arm=1 restarts the count from zero. The reload bit always reads 0. A write that leaves reload at 0, keeps arm=1 and keeps the code unchanged does not restart the count.
- R7: A write that changes the code to a different nonzero value while armed restarts the count from zero.
- R8: Counting starts only when the arm bit goes from 0 to 1. Writing arm=1 when it is already 1 (with the same code and no reload) does not restart an expired count. Writing arm=0 stops the count.
- R9: The `recover_src` output follows register bit 6 (0 = hardware strap selection, 1 = last software values), and it holds that value during the request cycle.
- R10: Writes to any address other than CTRL_ADDR are ignored. Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data |
| alarm | output | 1 | Sticky timeout flag |
| recover_req | output | 1 | One-cycle request to revert the frequency |
| recover_src | output | 1 | Recovery source: 0 hardware straps, 1 software values |

## Verification
The assertions assume that a write is a single-cycle strobe and that the write address and data are known whenever `wr_en` is high. They also assume that reset is held across at least one clock edge at startup. The bench changes inputs only on falling edges, and it drops `wr_en` after exactly one rising edge. Before each scenario it clears the alarm and disarms the block by writing 0x00, so that every timed window starts from a known write edge with a cleared prescaler.

// File: rtl/wdr_pkg.sv
// Package: shared field positions, widths and the control-word type for the
// watchdog. Assumes an 8-bit register data path.
package wdr_pkg;
    localparam int CODE_W  = 4;
    localparam int DATA_W  = 8;
    localparam int SEC_W   = CODE_W + 1;
    localparam int BIT_RLD = 4;
    localparam int BIT_ALM = 5;
    localparam int BIT_SRC = 6;
    localparam int BIT_ARM = 7;

    typedef struct packed {
        logic              arm;
        logic              src;
        logic [CODE_W-1:0] code;
    } wdr_cfg_t;

    // Timeout limit in seconds: two seconds per code step.
    function automatic logic [SEC_W-1:0] limit_of(input logic [CODE_W-1:0] c);
        return {c, 1'b0};
    endfunction
endpackage

// File: rtl/wdr_tick_gen.sv
// Module: seconds prescaler. Emits a one-cycle tick every DIV clocks.
// Assumes clr restarts the phase so the first tick lands DIV cycles later.
module wdr_tick_gen #(
    parameter int unsigned DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Divider counter, wrapping at LAST and cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick output on the last phase of the divider.
    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/wdr_ctrl_regs.sv
// Module: control register and write decode. Produces the stored config,
// a restart pulse (arm rising, reload, or code change while armed) and an
// alarm clear pulse (write of code 0000). Assumes single-cycle write strobes.
module wdr_ctrl_regs
    import wdr_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              alarm,
    output logic [DATA_W-1:0] rd_data,
    output wdr_cfg_t          cfg,
    output logic              restart,
    output logic              alarm_clr
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

    wdr_cfg_t cfg_q;
    wdr_cfg_t cfg_d;
    logic     wr_hit;

    // Decode the incoming write into config fields.
    always_comb begin
        wr_hit     = wr_en && (wr_addr == HIT_ADDR);
        cfg_d.arm  = wr_data[BIT_ARM];
        cfg_d.src  = wr_data[BIT_SRC];
        cfg_d.code = wr_data[CODE_W-1:0];
    end

    // Config storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            cfg_q <= cfg_d;
        end
    end

    // Restart and alarm-clear decisions from the write against stored state.
    always_comb begin
        restart   = wr_hit && cfg_d.arm &&
                    (wr_data[BIT_RLD] || !cfg_q.arm || (cfg_d.code != cfg_q.code));
        alarm_clr = wr_hit && (cfg_d.code == '0);
    end

    // Read view of the control word; reload always reads zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == HIT_ADDR) begin
            rd_data[CODE_W-1:0] = cfg_q.code;
            rd_data[BIT_ALM]    = alarm;
            rd_data[BIT_SRC]    = cfg_q.src;
            rd_data[BIT_ARM]    = cfg_q.arm;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/wdr_sec_counter.sv
// Module: seconds counter with stop-on-expiry. Flags 'hit' in the cycle the
// final tick arrives. Assumes 'active' falls or 'restart' pulses to rearm.
module wdr_sec_counter
    import wdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    logic [SEC_W-1:0] cnt_q;
    logic             done_q;
    logic [SEC_W-1:0] cnt_nx;

    // Next count and expiry detection for this tick.
    always_comb begin
        cnt_nx = cnt_q + SEC_W'(1);
        hit    = active && !done_q && !restart && tick && (cnt_nx == limit_of(code));
    end

    // Count seconds until the limit, then hold until restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (tick && !done_q) begin
            cnt_q <= cnt_nx;
            if (hit) begin
                done_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdr_watchdog_top.sv
// Module: watchdog top. Joins register, prescaler and seconds counter,
// and registers the alarm and the one-cycle recovery request.
// Assumes synchronous active-low reset and one register write per cycle.
module wdr_watchdog_top
    import wdr_pkg::*;
#(
    parameter int          ADDR_W    = 2,
    parameter int          CTRL_ADDR = 0,
    parameter int unsigned TICK_DIV  = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              alarm,
    output logic              recover_req,
    output logic              recover_src
);
    wdr_cfg_t cfg;
    logic     restart;
    logic     alarm_clr;
    logic     active;
    logic     tick;
    logic     hit;
    logic     fire;
    logic     alarm_q;
    logic     req_q;

    wdr_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .alarm    (alarm_q),
        .rd_data  (rd_data),
        .cfg      (cfg),
        .restart  (restart),
        .alarm_clr(alarm_clr)
    );

    // Counting is enabled only when armed with a nonzero code.
    assign active = cfg.arm && (cfg.code != '0);

    wdr_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart || !active),
        .tick (tick)
    );

    wdr_sec_counter cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .restart(restart),
        .active (active),
        .code   (cfg.code),
        .hit    (hit)
    );

    // An alarm clear in the same cycle suppresses the expiry.
    assign fire = hit && !alarm_clr;

    // Sticky alarm: set on expiry, cleared only by a code-0000 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if (alarm_clr) begin
            alarm_q <= 1'b0;
        end else if (fire) begin
            alarm_q <= 1'b1;
        end
    end

    // One-cycle recovery request aligned with the alarm rising.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= fire;
        end
    end

    assign alarm       = alarm_q;
    assign recover_req = req_q;
    assign recover_src = cfg.src;
endmodule

// File: rtl/wdr_watchdog_chk.sv
// Module: assertion checker bound to the watchdog top.
// Assumes single-cycle write strobes with known address and data.
module wdr_watchdog_chk #(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              alarm,
    input logic              recover_req,
    input logic [3:0]        code
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && (wr_data[3:0] == 4'd0);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!alarm && !recover_req));

    a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'd0) |=> !recover_req);

    a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |=> !recover_req);

    a_r4_req_with_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |-> alarm);

    a_r5_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clr_wr) |=> alarm);

    a_r5_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !alarm);
endmodule

bind wdr_watchdog_top wdr_watchdog_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .alarm      (alarm),
    .recover_req(recover_req),
    .code       (cfg.code)
);

// File: tb/wdr_watchdog_top_tb_top.sv
module wdr_watchdog_top_tb_top;
    localparam int ADDR_W = 2;
    localparam int DIV    = 10;
    localparam logic [7:0] ARM = 8'h80;
    localparam logic [7:0] SRC = 8'h40;
    localparam logic [7:0] RLD = 8'h10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              alarm;
    logic              recover_req;
    logic              recover_src;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    wdr_watchdog_top #(.ADDR_W(ADDR_W), .CTRL_ADDR(0), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .alarm(alarm),
        .recover_req(recover_req), .recover_src(recover_src)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Write; the write edge is the rising edge between the two falling edges.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // Returns number of edges after the write edge until recover_req, or -1.
    task automatic wait_req(input int max, output int k);
        int i = 0;
        k = -1;
        while (k < 0 && i < max) begin
            @(posedge clk);
            @(negedge clk);
            i++;
            if (recover_req) k = i;
        end
    endtask

    task automatic t_reset;
        check(rd_data == 8'h00, "R1 reg", rd_data, 0);
        check(!alarm && !recover_req, "R1 outputs", {alarm, recover_req}, 0);
    endtask

    task automatic t_timeout(input int n, input logic [7:0] s);
        int k;
        do_write(0, 8'h00);
        do_write(0, ARM | s | 8'(n));
        check(rd_data == (ARM | s | 8'(n)), "R9 readback", rd_data, ARM | s | 8'(n));
        wait_req(2 * n * DIV + 5, k);
        check(k == 2 * n * DIV, "R3 timeout edges", k, 2 * n * DIV);
        check(alarm == 1'b1 && rd_data[5] == 1'b1, "R4 alarm with req", alarm, 1);
        check(recover_src == s[6], "R9 recover_src", recover_src, s[6]);
        @(negedge clk);
        check(recover_req == 1'b0, "R4 single cycle", recover_req, 0);
        wait_req(4 * DIV, k);
        check(k == -1, "R4 stopped after expiry", k, -1);
    endtask

    task automatic t_reload;
        int k;
        do_write(0, 8'h00);
        do_write(0, ARM | 8'd2);
        wait_req(25, k);
        check(k == -1, "R6 no early req", k, -1);
        do_write(0, ARM | RLD | 8'd2);
        check(rd_data == (ARM | 8'd2), "R6 reload reads 0", rd_data, ARM | 8'd2);
        wait_req(45, k);
        check(k == 40, "R6 reload restart", k, 40);
        do_write(0, 8'h00);
        do_write(0, ARM | 8'd2);
        wait_req(15, k);
        do_write(0, ARM | 8'd2);
        wait_req(30, k);
        check(k == 23, "R6 reload 0 no restart", k, 23);
    endtask

    task automatic t_code_change;
        int k;
        do_write(0, 8'h00);
        do_write(0, ARM | 8'd3);
        wait_req(20, k);
        check(k == -1, "R7 no early req", k, -1);
        do_write(0, ARM | 8'd1);
        wait_req(25, k);
        check(k == 20, "R7 code change restart", k, 20);
    endtask

    task automatic t_arm_edge;
        int k;
        t_timeout(1, 8'h00);
        do_write(0, ARM | 8'd1);
        wait_req(40, k);
        check(k == -1, "R8 stale arm no restart", k, -1);
        do_write(0, 8'd1);
        wait_req(40, k);
        check(k == -1, "R8 disarmed no count", k, -1);
        check(alarm == 1'b1, "R5 alarm sticky", alarm, 1);
        do_write(0, ARM | 8'd1);
        wait_req(25, k);
        check(k == 20, "R8 arm rising edge", k, 20);
    endtask

    task automatic t_alarm_off;
        int k;
        do_write(0, ARM | RLD | 8'd1);
        check(alarm == 1'b1, "R5 alarm kept on reload", alarm, 1);
        do_write(0, ARM);
        check(alarm == 1'b0 && rd_data == ARM, "R5 alarm cleared", rd_data, ARM);
        wait_req(100, k);
        check(k == -1, "R2 code 0000 off", k, -1);
    endtask

    task automatic t_addr;
        int k;
        do_write(1, 8'hFF);
        check(rd_data == ARM, "R10 other addr write ignored", rd_data, ARM);
        rd_addr = 1;
        #1;
        check(rd_data == 8'h00, "R10 other addr reads 0", rd_data, 0);
        rd_addr = 0;
        wait_req(40, k);
        check(k == -1, "R10 no arming", k, -1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timeout(1, 8'h00);
        t_timeout(3, SRC);
        t_timeout(15, 8'h00);
        t_reload();
        t_code_change();
        t_arm_edge();
        t_alarm_off();
        t_addr();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end
endmodule